// File: doc/BRIEF.md
# Linear CCD Drive Clock Generator

This block derives every digital drive clock of a three-colour linear CCD sensor from one system clock. The sensor reads each colour row through two outputs: one carries the odd pixels and one the even pixels. The block drives one transfer-gate pulse shared by the three colour rows. It also drives two complementary shift phases, a last-stage shift phase that follows phase 1, a reset-gate pulse and a reset-level clamp pulse. Two strobes go to the capture logic downstream: one marks the start of each line, and one marks each shift period that carries valid pixels.

A line consists of a run of pixel-shift periods followed by a transfer window. During the transfer window the shift phases are frozen with phase 1 high, and a guard interval lies before and after the transfer-gate pulse. The reset-gate and clamp pulses keep running through the whole line without a gap.

Three timings are taken from configuration inputs while reset is held: the shift count per line (which sets the storage time), the transfer-gate width and the guard length. A value below its minimum is replaced by that minimum, and an error flag is raised. The pixel-level timing is fixed by parameters: the pixel period, the pulse widths and the reset-to-clamp spacing. The spacing may be set to a one-cycle overlap.

Top module: `ccd_clock_gen`

## Requirements
- R1: While `rst` is high, the outputs show the idle state: `ccd_tg` low, `ccd_ph1` high, `ccd_ph2` low, both strobes low. The pixel counter is at position 0, so `ccd_rst_gate` is high.
- R2: `ccd_ph2` is always the complement of `ccd_ph1`, and `ccd_ph1_last` always equals `ccd_ph1`.
- R3: While shifting, each shift period lasts PIX_CYC cycles. `ccd_ph1` is high for the first PIX_CYC/2 cycles of the period and low for the rest. A line holds exactly the configured number of shift periods.
- R4: `ccd_rst_gate` is high at positions 0 to RB_W-1 of every pixel period. `ccd_clamp` is high for CLB_W cycles starting at position RB_W+RB_CLB_GAP. Both pulses run in every line phase, including the transfer window. A gap of -1 makes the two pulses overlap by one cycle.
- R5: After the last shift period, `ccd_ph1` stays high and `ccd_tg` stays low for G cycles. `ccd_tg` is then high for T cycles. After that, the phases stay frozen for at least G more cycles, until the next pixel-period boundary, where shifting resumes. The first line after reset begins with this window.
- R6: While `rst` is high, each configuration input is captured. A value below its minimum is replaced by the minimum. `cfg_err` is high when any field was below its minimum and holds that value until the next reset.
- R7: `line_start` is high for exactly one cycle: the first cycle of the first shift period of each line.
- R8: `pix_valid` is high on the last cycle of the shift periods with index k (counted from 0) in the range FIRST_VALID <= k < FIRST_VALID+VALID_PIX/2. FIRST_VALID is (OB_PIX+LEAD_INV)/2, because each period moves one odd and one even pixel.
- R9: The smallest accepted shift count is (TOTAL_POS+1)/2. With this count, shifting reaches the last register position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while it is high |
| cfg_line_shifts | input | CFG_W | Shift periods per line (storage time) |
| cfg_tg_cycles | input | CFG_W | Transfer-gate pulse width in cycles |
| cfg_guard_cycles | input | CFG_W | Guard length around the transfer pulse in cycles |
| ccd_tg | output | 1 | Transfer-gate pulse shared by the three colour rows |
| ccd_ph1 | output | 1 | Shift phase 1 |
| ccd_ph2 | output | 1 | Shift phase 2 (complement of phase 1) |
| ccd_ph1_last | output | 1 | Last-stage shift phase |
| ccd_rst_gate | output | 1 | Reset-gate pulse |
| ccd_clamp | output | 1 | Reset-level clamp pulse |
| line_start | output | 1 | One-cycle strobe at the start of the shift run of each line |
| pix_valid | output | 1 | One-cycle strobe per shift period that carries valid pixels |
| cfg_err | output | 1 | A configuration field was below its minimum at the last reset |

## Verification
Every output is decoded without delay from registered state, so each output changes in the cycle that follows the clock edge that moved the state. The first cycle after reset release already shows the captured configuration and the start of the guard interval. The bench computes, for each cycle since reset release, the expected line origin, the transfer window and the first shift cycle. The first shift cycle is the first multiple of PIX_CYC at or after origin+2G+T. The bench compares all nine outputs against this schedule half a cycle after each edge, so every expected value falls in the same cycle as the design's change.

// File: rtl/ccdclk_pkg.sv
package ccdclk_pkg;

  typedef enum logic [1:0] {
    SEQ_PRE   = 2'd0,
    SEQ_TG    = 2'd1,
    SEQ_POST  = 2'd2,
    SEQ_SHIFT = 2'd3
  } seq_state_t;

  // raise a value to a floor
  function automatic int at_least(int v, int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // position inside a half-open window [start, start+len)
  function automatic logic in_window(int pos, int start, int len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
  parameter int                   CFG_W   = 16,
  parameter int                   NF      = 3,
  parameter logic [NF*CFG_W-1:0]  MIN_VEC = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NF*CFG_W-1:0]   raw,
  output logic [NF*CFG_W-1:0]   eff,
  output logic                  err
);

  logic [NF-1:0] low;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_field
      logic [CFG_W-1:0] raw_f;
      logic [CFG_W-1:0] min_f;
      logic [CFG_W-1:0] eff_q;

      assign raw_f  = raw[i*CFG_W +: CFG_W];
      assign min_f  = MIN_VEC[i*CFG_W +: CFG_W];
      assign low[i] = raw_f < min_f;

      always_ff @(posedge clk) begin
        if (rst) eff_q <= low[i] ? min_f : raw_f;
      end

      assign eff[i*CFG_W +: CFG_W] = eff_q;

      // R6: a field in use never sits below its floor
      p_floor_r6: assert property (@(posedge clk) disable iff (rst)
        eff_q >= min_f);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) err <= |low;
  end

  // R6: the error flag is frozen outside reset
  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $stable(err));

endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer
  import ccdclk_pkg::*;
#(
  parameter int PIX_CYC   = 8,
  parameter int RB_LEN    = 2,
  parameter int CLB_START = 3,
  parameter int CLB_LEN   = 2
) (
  input  logic clk,
  input  logic rst,
  output logic pix_first,
  output logic pix_end,
  output logic ph_hi,
  output logic rb,
  output logic clb
);

  localparam int PCW  = (PIX_CYC > 1) ? $clog2(PIX_CYC) : 1;
  localparam int HALF = PIX_CYC / 2;

  logic [PCW-1:0] pc;
  int             pos;

  always_ff @(posedge clk) begin
    if (rst)                          pc <= '0;
    else if (pc == PCW'(PIX_CYC - 1)) pc <= '0;
    else                              pc <= pc + PCW'(1);
  end

  always_comb begin
    pos       = int'(pc);
    pix_first = (pos == 0);
    pix_end   = (pos == PIX_CYC - 1);
    ph_hi     = (pos < HALF);
    rb        = in_window(pos, 0, RB_LEN);
    clb       = in_window(pos, CLB_START, CLB_LEN);
  end

  // R4: the reset pulse opens every period, right after the wrap
  p_rb_after_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    pix_end |=> rb);
  p_rb_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rb) |-> pix_first);

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccdclk_pkg::*;
#(
  parameter int CFG_W        = 16,
  parameter int FIRST_VALID  = 51,
  parameter int VALID_SHIFTS = 2500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_first,
  input  logic             pix_end,
  input  logic             ph_hi,
  input  logic [CFG_W-1:0] n_shift,
  input  logic [CFG_W-1:0] tg_len,
  input  logic [CFG_W-1:0] guard_len,
  output logic             tg,
  output logic             ph1,
  output logic             ph2,
  output logic             ph1_last,
  output logic             line_start,
  output logic             pix_valid
);

  seq_state_t       st;
  logic [CFG_W-1:0] cnt;
  logic [CFG_W-1:0] kidx;
  logic             shifting;
  logic             guard_done;
  logic             tg_done;
  logic             last_shift;
  logic             in_valid;

  assign guard_done = cnt >= guard_len - CFG_W'(1);
  assign tg_done    = cnt == tg_len - CFG_W'(1);
  assign last_shift = kidx == n_shift - CFG_W'(1);
  assign in_valid   = (kidx >= CFG_W'(FIRST_VALID)) &&
                      (kidx <  CFG_W'(FIRST_VALID + VALID_SHIFTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SEQ_PRE;
      cnt  <= '0;
      kidx <= '0;
    end else begin
      case (st)
        SEQ_PRE: begin
          if (guard_done) begin st <= SEQ_TG; cnt <= '0; end
          else cnt <= cnt + CFG_W'(1);
        end
        SEQ_TG: begin
          if (tg_done) begin st <= SEQ_POST; cnt <= '0; end
          else cnt <= cnt + CFG_W'(1);
        end
        SEQ_POST: begin
          if (guard_done && pix_end) begin st <= SEQ_SHIFT; kidx <= '0; end
          else if (!guard_done) cnt <= cnt + CFG_W'(1);
        end
        default: begin
          if (pix_end) begin
            if (last_shift) begin st <= SEQ_PRE; cnt <= '0; end
            else kidx <= kidx + CFG_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    shifting   = (st == SEQ_SHIFT);
    tg         = (st == SEQ_TG);
    ph1        = shifting ? ph_hi : 1'b1;
    ph2        = !ph1;
    ph1_last   = ph1;
    line_start = shifting && pix_first && (kidx == '0);
    pix_valid  = shifting && pix_end && in_valid;
  end

  // R5: phases are frozen for the whole transfer pulse
  p_tg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    tg |-> (ph1 && !shifting));
  // R5: shifting resumes only on a pixel-period boundary
  p_restart_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(shifting) |-> pix_first);
  // R3: a shift run ends only after a full period
  p_shift_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(shifting) |-> $past(pix_end));
  // R7: line strobe is one cycle wide
  p_ls_single_r7: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
  // R8: valid strobe only at the end of a shift period
  p_valid_edge_r8: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (shifting && pix_end));

endmodule

// File: rtl/ccd_clock_gen.sv
module ccd_clock_gen
  import ccdclk_pkg::*;
#(
  parameter int PIX_CYC    = 8,
  parameter int RB_W       = 2,
  parameter int CLB_W      = 2,
  parameter int RB_CLB_GAP = 1,
  parameter int MIN_PULSE  = 2,
  parameter int MIN_GAP    = -1,
  parameter int OB_PIX     = 96,
  parameter int LEAD_INV   = 6,
  parameter int VALID_PIX  = 5000,
  parameter int TOTAL_POS  = 5138,
  parameter int MIN_TG     = 500,
  parameter int MIN_GUARD  = 90,
  parameter int CFG_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_line_shifts,
  input  logic [CFG_W-1:0] cfg_tg_cycles,
  input  logic [CFG_W-1:0] cfg_guard_cycles,
  output logic             ccd_tg,
  output logic             ccd_ph1,
  output logic             ccd_ph2,
  output logic             ccd_ph1_last,
  output logic             ccd_rst_gate,
  output logic             ccd_clamp,
  output logic             line_start,
  output logic             pix_valid,
  output logic             cfg_err
);

  localparam int RB_LEN       = at_least(RB_W, MIN_PULSE);
  localparam int CLB_LEN      = at_least(CLB_W, MIN_PULSE);
  localparam int GAP_EFF      = at_least(RB_CLB_GAP, MIN_GAP);
  localparam int CLB_START    = RB_LEN + GAP_EFF;
  localparam int MIN_SHIFTS   = (TOTAL_POS + 1) / 2;
  localparam int FIRST_VALID  = (OB_PIX + LEAD_INV) / 2;
  localparam int VALID_SHIFTS = VALID_PIX / 2;
  localparam int NF           = 3;
  localparam logic [NF*CFG_W-1:0] MIN_VEC =
    {CFG_W'(MIN_GUARD), CFG_W'(MIN_TG), CFG_W'(MIN_SHIFTS)};

  logic [NF*CFG_W-1:0] cfg_raw;
  logic [NF*CFG_W-1:0] cfg_eff;
  logic                pix_first;
  logic                pix_end;
  logic                ph_hi;

  assign cfg_raw = {cfg_guard_cycles, cfg_tg_cycles, cfg_line_shifts};

  ccd_cfg_check #(
    .CFG_W  (CFG_W),
    .NF     (NF),
    .MIN_VEC(MIN_VEC)
  ) i_cfg (
    .clk(clk),
    .rst(rst),
    .raw(cfg_raw),
    .eff(cfg_eff),
    .err(cfg_err)
  );

  ccd_pix_timer #(
    .PIX_CYC  (PIX_CYC),
    .RB_LEN   (RB_LEN),
    .CLB_START(CLB_START),
    .CLB_LEN  (CLB_LEN)
  ) i_pix (
    .clk      (clk),
    .rst      (rst),
    .pix_first(pix_first),
    .pix_end  (pix_end),
    .ph_hi    (ph_hi),
    .rb       (ccd_rst_gate),
    .clb      (ccd_clamp)
  );

  ccd_line_seq #(
    .CFG_W       (CFG_W),
    .FIRST_VALID (FIRST_VALID),
    .VALID_SHIFTS(VALID_SHIFTS)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .pix_first (pix_first),
    .pix_end   (pix_end),
    .ph_hi     (ph_hi),
    .n_shift   (cfg_eff[0*CFG_W +: CFG_W]),
    .tg_len    (cfg_eff[1*CFG_W +: CFG_W]),
    .guard_len (cfg_eff[2*CFG_W +: CFG_W]),
    .tg        (ccd_tg),
    .ph1       (ccd_ph1),
    .ph2       (ccd_ph2),
    .ph1_last  (ccd_ph1_last),
    .line_start(line_start),
    .pix_valid (pix_valid)
  );

  // R2: the phase outputs stay complementary across every line phase
  p_phase_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (ccd_ph1 != ccd_ph2) && (ccd_ph1_last == ccd_ph1));
  // R4: pulses continue through the transfer window
  p_rb_in_tg_r4: assert property (@(posedge clk) disable iff (rst)
    (ccd_tg && pix_first) |-> ccd_rst_gate);

endmodule

// File: tb/test_ccd_clock_gen.sv
module test_ccd_clock_gen;

  localparam int P      = 8;
  localparam int RBW    = 2;
  localparam int CLBW   = 2;
  localparam int GAP    = -1;
  localparam int OB     = 4;
  localparam int LEAD   = 2;
  localparam int VALID  = 8;
  localparam int TOTAL  = 20;
  localparam int MTG    = 12;
  localparam int MGUARD = 4;
  localparam int CW     = 16;
  localparam int MIN_N  = (TOTAL + 1) / 2;
  localparam int FV     = (OB + LEAD) / 2;
  localparam int VS     = VALID / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_n = 16'd12;
  logic [CW-1:0] cfg_t = 16'd15;
  logic [CW-1:0] cfg_g = 16'd5;
  logic tg, ph1, ph2, ph1l, rbo, clbo, ls, pv, err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ccd_clock_gen #(
    .PIX_CYC(P), .RB_W(RBW), .CLB_W(CLBW), .RB_CLB_GAP(GAP), .MIN_PULSE(2),
    .MIN_GAP(-1), .OB_PIX(OB), .LEAD_INV(LEAD), .VALID_PIX(VALID),
    .TOTAL_POS(TOTAL), .MIN_TG(MTG), .MIN_GUARD(MGUARD), .CFG_W(CW)
  ) i_ccd_clock_gen (
    .clk(clk), .rst(rst),
    .cfg_line_shifts(cfg_n), .cfg_tg_cycles(cfg_t), .cfg_guard_cycles(cfg_g),
    .ccd_tg(tg), .ccd_ph1(ph1), .ccd_ph2(ph2), .ccd_ph1_last(ph1l),
    .ccd_rst_gate(rbo), .ccd_clamp(clbo), .line_start(ls), .pix_valid(pv),
    .cfg_err(err)
  );

  task automatic chk(string tag, int t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, t, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic episode(int n, int tl, int g, int cycles, bit floor_case);
    int  ne, te, ge, org, s, nxt, pc, k;
    bit  sh, e_err;
    string ph_tag;
    ne = (n < MIN_N) ? MIN_N : n;
    te = (tl < MTG) ? MTG : tl;
    ge = (g < MGUARD) ? MGUARD : g;
    e_err = (n < MIN_N) || (tl < MTG) || (g < MGUARD);
    ph_tag = floor_case ? "R9 ph1 with raised shift count" : "R3 ph1";
    @(negedge clk);
    rst = 1'b1;
    cfg_n = CW'(n); cfg_t = CW'(tl); cfg_g = CW'(g);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chk("R1 tg in reset", -1, tg, 1'b0);
      chk("R1 ph1 in reset", -1, ph1, 1'b1);
      chk("R1 ph2 in reset", -1, ph2, 1'b0);
      chk("R1 line_start in reset", -1, ls, 1'b0);
      chk("R1 pix_valid in reset", -1, pv, 1'b0);
      chk("R1 rst_gate in reset", -1, rbo, 1'b1);
    end
    @(negedge clk);
    rst = 1'b0;
    org = 0;
    for (int t = 0; t < cycles; t++) begin
      #1;
      s   = org + ((2 * ge + te + P - 1) / P) * P;
      nxt = s + ne * P;
      if (t >= nxt) begin
        org = nxt;
        s   = org + ((2 * ge + te + P - 1) / P) * P;
        nxt = s + ne * P;
      end
      pc = t % P;
      sh = (t >= s);
      k  = sh ? (t - s) / P : -1;
      chk("R5 tg window", t, tg, (t >= org + ge) && (t < org + ge + te));
      chk(ph_tag, t, ph1, sh ? (pc < P / 2) : 1'b1);
      chk("R2 ph2 complement", t, ph2, sh ? !(pc < P / 2) : 1'b0);
      chk("R2 ph1_last", t, ph1l, sh ? (pc < P / 2) : 1'b1);
      chk("R4 rst_gate", t, rbo, pc < RBW);
      chk("R4 clamp (overlap gap)", t, clbo, (pc >= RBW + GAP) && (pc < RBW + GAP + CLBW));
      chk("R7 line_start", t, ls, t == s);
      chk("R8 pix_valid", t, pv, sh && (pc == P - 1) && (k >= FV) && (k < FV + VS));
      chk("R6 cfg_err", t, err, e_err);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    episode(12, 15, 5, 400, 1'b0);   // above the floors
    episode(3, 4, 1, 400, 1'b1);     // R6/R9: all fields raised to the floors
    episode(MIN_N, MTG, MGUARD, 400, 1'b1); // exactly at the floors
    episode(13, 20, 7, 450, 1'b0);   // guard not aligned to a pixel period
    done = 1'b1;
    summary();
    $finish;
  end

endmodule